// File: doc/BRIEF.md
# Three-Port Mailbox Interrupt Flags

This block keeps the four mailbox interrupt flags of a RAM shared by three ports. One port is the host. It carries two active-low byte-lane enables. The other two ports are peers, and each has one active-low select. The block does not hold the RAM array or any data path. It only watches each port's address, read/write level and enable strobes, and it treats them as one access per clock.

Two addresses at the top of the 12-bit space act as mailboxes. A peer writing the host mailbox raises an interrupt towards the host. The host writing the peer mailbox raises an interrupt towards whichever peers its lane enables pick. Each receiver clears its own interrupt by any access, read or write, to its own mailbox. The flags are registered. Each one drives an active-low interrupt output.

Top module: `tpmb_flags_top`

## Requirements
- R1: While reset is asserted and after it is released, with no access, all four interrupt outputs are high.
- R2: A peer-2 write (select low, rw_n low) to address 0xFFE sets the host's peer-2 flag, so host_irq2_n goes low.
- R3: A peer-3 write (select low, rw_n low) to address 0xFFE sets the host's peer-3 flag, so host_irq3_n goes low.
- R4: A host access to 0xFFE clears the host's peer-2 flag when lane_n[0] is low, and the host's peer-3 flag when lane_n[1] is low. The rw_n level does not matter. With both lanes low, both flags clear.
- R5: A host write (rw_n low) to 0xFFF sets peer 2's flag when lane_n[0] is low, and peer 3's flag when lane_n[1] is low. With both lanes low, both flags set.
- R6: A peer access to 0xFFF with its select low clears that peer's own flag. The rw_n level does not matter.
- R7: The following change no flag: reads of a mailbox that would be set by a write, accesses with the select or lane enables high, and accesses to any other address.
- R8: If a flag sees a set and a clear in the same clock, it ends up set.
- R9: A flag with neither a set nor a clear keeps its value. Each interrupt output is low exactly while its flag is set.
- R10: A flag changes on the first rising clock edge that samples the access, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 12 | Host port address |
| host_rw_n | input | 1 | Host read (1) / write (0) |
| host_lane_n | input | 2 | Host byte-lane enables, active low; bit 0 pairs with peer 2, bit 1 with peer 3 |
| peer2_addr | input | 12 | Peer 2 address |
| peer2_rw_n | input | 1 | Peer 2 read (1) / write (0) |
| peer2_sel_n | input | 1 | Peer 2 select, active low |
| peer3_addr | input | 12 | Peer 3 address |
| peer3_rw_n | input | 1 | Peer 3 read (1) / write (0) |
| peer3_sel_n | input | 1 | Peer 3 select, active low |
| host_irq2_n | output | 1 | Host interrupt from peer 2, active low |
| host_irq3_n | output | 1 | Host interrupt from peer 3, active low |
| peer2_irq_n | output | 1 | Peer 2 interrupt, active low |
| peer3_irq_n | output | 1 | Peer 3 interrupt, active low |

## Verification
Each flag is one register stage after the decode. An access is therefore due at the outputs after the first rising edge that samples it, and it must not show before that edge. The bench drives every access on a falling edge and checks the outputs on the next falling edge, half a period after the flag registers load. One directed check also samples shortly after driving, before the edge, to confirm nothing has moved yet. A long sweep drives all three ports at once, with addresses picked from the two mailboxes and two other addresses. For every cycle it predicts all four flags from the requirement rules and compares them at that same falling edge.

// File: rtl/tpmb_pkg.sv
package tpmb_pkg;
  // flag vector positions shared by top, checker and bench
  localparam int FLAG_N     = 4;
  localparam int FL_HOST_P2 = 0;
  localparam int FL_HOST_P3 = 1;
  localparam int FL_PEER2   = 2;
  localparam int FL_PEER3   = 3;

  // next state of a single flag: a set beats a clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/tpmb_host_dec.sv
module tpmb_host_dec #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 2,
  parameter logic [ADDR_W-1:0] HOST_BOX = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw_n,
  input  logic [LANES-1:0]  lane_n,
  output logic [LANES-1:0]  set_peer,
  output logic [LANES-1:0]  clr_host
);
  logic hit_host, hit_peer;
  assign hit_host = (addr == HOST_BOX);
  assign hit_peer = (addr == PEER_BOX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign set_peer[g] = hit_peer && !rw_n && !lane_n[g];
    assign clr_host[g] = hit_host && !lane_n[g];
  end
endmodule

// File: rtl/tpmb_peer_dec.sv
module tpmb_peer_dec #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HOST_BOX = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw_n,
  input  logic              sel_n,
  output logic              set_host,
  output logic              clr_own
);
  assign set_host = !sel_n && !rw_n && (addr == HOST_BOX);
  assign clr_own  = !sel_n && (addr == PEER_BOX);
endmodule

// File: rtl/tpmb_flag_bank.sv
module tpmb_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irq_n
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= tpmb_pkg::flag_next(flag_q[g], set[g], clr[g]);
    end
  end

  assign irq_n = ~flag_q;
endmodule

// File: rtl/tpmb_flags_top.sv
module tpmb_flags_top #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rw_n,
  input  logic [1:0]        host_lane_n,
  input  logic [ADDR_W-1:0] peer2_addr,
  input  logic              peer2_rw_n,
  input  logic              peer2_sel_n,
  input  logic [ADDR_W-1:0] peer3_addr,
  input  logic              peer3_rw_n,
  input  logic              peer3_sel_n,
  output logic              host_irq2_n,
  output logic              host_irq3_n,
  output logic              peer2_irq_n,
  output logic              peer3_irq_n
);
  import tpmb_pkg::*;

  localparam logic [ADDR_W-1:0] PEER_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] HOST_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

  // named event wires, visible to the bound checker
  logic [1:0]        host_set_peer, host_clr_host;
  logic              p2_set_host, p2_clr_own;
  logic              p3_set_host, p3_clr_own;
  logic [FLAG_N-1:0] set_vec, clr_vec, irq_vec_n;

  tpmb_host_dec #(.ADDR_W(ADDR_W), .LANES(2), .HOST_BOX(HOST_BOX), .PEER_BOX(PEER_BOX)) u_host (
    .addr(host_addr), .rw_n(host_rw_n), .lane_n(host_lane_n),
    .set_peer(host_set_peer), .clr_host(host_clr_host)
  );

  tpmb_peer_dec #(.ADDR_W(ADDR_W), .HOST_BOX(HOST_BOX), .PEER_BOX(PEER_BOX)) u_p2 (
    .addr(peer2_addr), .rw_n(peer2_rw_n), .sel_n(peer2_sel_n),
    .set_host(p2_set_host), .clr_own(p2_clr_own)
  );

  tpmb_peer_dec #(.ADDR_W(ADDR_W), .HOST_BOX(HOST_BOX), .PEER_BOX(PEER_BOX)) u_p3 (
    .addr(peer3_addr), .rw_n(peer3_rw_n), .sel_n(peer3_sel_n),
    .set_host(p3_set_host), .clr_own(p3_clr_own)
  );

  always_comb begin
    set_vec[FL_HOST_P2] = p2_set_host;
    set_vec[FL_HOST_P3] = p3_set_host;
    set_vec[FL_PEER2]   = host_set_peer[0];
    set_vec[FL_PEER3]   = host_set_peer[1];
    clr_vec[FL_HOST_P2] = host_clr_host[0];
    clr_vec[FL_HOST_P3] = host_clr_host[1];
    clr_vec[FL_PEER2]   = p2_clr_own;
    clr_vec[FL_PEER3]   = p3_clr_own;
  end

  tpmb_flag_bank #(.N(FLAG_N)) u_bank (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .irq_n(irq_vec_n)
  );

  assign host_irq2_n = irq_vec_n[FL_HOST_P2];
  assign host_irq3_n = irq_vec_n[FL_HOST_P3];
  assign peer2_irq_n = irq_vec_n[FL_PEER2];
  assign peer3_irq_n = irq_vec_n[FL_PEER3];
endmodule

// File: rtl/tpmb_flags_chk.sv
module tpmb_flags_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rw_n,
  input logic [1:0]        host_lane_n,
  input logic [ADDR_W-1:0] peer2_addr,
  input logic              peer2_rw_n,
  input logic              peer2_sel_n,
  input logic [3:0]        set_vec,
  input logic [3:0]        clr_vec,
  input logic [3:0]        irq_n
);
  localparam logic [ADDR_W-1:0] PEER_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] HOST_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

  // R1: outputs idle high while in reset
  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (irq_n == 4'hF);
  end

  // R2: the peer-2 set event comes only from a real peer-2 write to the host mailbox
  assert_p2_set_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |-> (!peer2_sel_n && !peer2_rw_n && peer2_addr == HOST_BOX));

  // R5: the host set events need a host write to the peer mailbox
  assert_host_set_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[2] || set_vec[3]) |-> (!host_rw_n && host_addr == PEER_BOX && host_lane_n != 2'b11));

  for (genvar g = 0; g < 4; g++) begin : g_chk
    // R8: a set wins, so the output is low next cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> !irq_n[g]);
    // R4 / R6: a lone clear releases the output
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> irq_n[g]);
    // R9: no event, no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[g] && !set_vec[g]) |=> $stable(irq_n[g]));
  end
endmodule

bind tpmb_flags_top tpmb_flags_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .host_addr(host_addr), .host_rw_n(host_rw_n), .host_lane_n(host_lane_n),
  .peer2_addr(peer2_addr), .peer2_rw_n(peer2_rw_n), .peer2_sel_n(peer2_sel_n),
  .set_vec(set_vec), .clr_vec(clr_vec), .irq_n(irq_vec_n)
);

// File: tb/tpmb_flags_top_tb_top.sv
`timescale 1ns/1ps
module tpmb_flags_top_tb_top;
  localparam logic [11:0] HBOX = 12'hFFE;
  localparam logic [11:0] PBOX = 12'hFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] host_addr = '0, peer2_addr = '0, peer3_addr = '0;
  logic host_rw_n = 1'b1, peer2_rw_n = 1'b1, peer3_rw_n = 1'b1;
  logic [1:0] host_lane_n = 2'b11;
  logic peer2_sel_n = 1'b1, peer3_sel_n = 1'b1;
  logic host_irq2_n, host_irq3_n, peer2_irq_n, peer3_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_f = 4'h0; // {peer3, peer2, host3, host2}

  always #2.5 clk = ~clk;

  tpmb_flags_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_rw_n(host_rw_n), .host_lane_n(host_lane_n),
    .peer2_addr(peer2_addr), .peer2_rw_n(peer2_rw_n), .peer2_sel_n(peer2_sel_n),
    .peer3_addr(peer3_addr), .peer3_rw_n(peer3_rw_n), .peer3_sel_n(peer3_sel_n),
    .host_irq2_n(host_irq2_n), .host_irq3_n(host_irq3_n),
    .peer2_irq_n(peer2_irq_n), .peer3_irq_n(peer3_irq_n)
  );

  function automatic logic [3:0] outs();
    return {peer3_irq_n, peer2_irq_n, host_irq3_n, host_irq2_n};
  endfunction

  // expected flags after one clock, derived from the requirement rules
  function automatic logic [3:0] predict(logic [3:0] f);
    logic [3:0] s, c, n;
    s[0] = !peer2_sel_n && !peer2_rw_n && peer2_addr == HBOX;
    s[1] = !peer3_sel_n && !peer3_rw_n && peer3_addr == HBOX;
    s[2] = host_addr == PBOX && !host_rw_n && !host_lane_n[0];
    s[3] = host_addr == PBOX && !host_rw_n && !host_lane_n[1];
    c[0] = host_addr == HBOX && !host_lane_n[0];
    c[1] = host_addr == HBOX && !host_lane_n[1];
    c[2] = peer2_addr == PBOX && !peer2_sel_n;
    c[3] = peer3_addr == PBOX && !peer3_sel_n;
    n = (f & ~c) | s;
    return n;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s irq_n got %b expected %b", req, got, want);
    end
  endtask

  task automatic idle();
    host_addr = 12'h000; host_rw_n = 1'b1; host_lane_n = 2'b11;
    peer2_addr = 12'h000; peer2_rw_n = 1'b1; peer2_sel_n = 1'b1;
    peer3_addr = 12'h000; peer3_rw_n = 1'b1; peer3_sel_n = 1'b1;
  endtask

  // inputs already driven; wait one clock, then compare at the falling edge
  task automatic step(string req);
    exp_f = predict(exp_f);
    @(negedge clk);
    check(req, outs(), ~exp_f);
    idle();
  endtask

  task automatic host_acc(logic [11:0] a, logic rw, logic [1:0] ln);
    host_addr = a; host_rw_n = rw; host_lane_n = ln;
  endtask
  task automatic p2_acc(logic [11:0] a, logic rw, logic sel);
    peer2_addr = a; peer2_rw_n = rw; peer2_sel_n = sel;
  endtask
  task automatic p3_acc(logic [11:0] a, logic rw, logic sel);
    peer3_addr = a; peer3_rw_n = rw; peer3_sel_n = sel;
  endtask

  function automatic logic [11:0] pick(logic [1:0] k);
    case (k)
      2'd0: return HBOX;
      2'd1: return PBOX;
      2'd2: return 12'h000;
      default: return 12'h7FE;
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), 4'hF);

    // R2 and R10: no change before the edge, change after it
    p2_acc(HBOX, 1'b0, 1'b0);
    #1 check("R10 before edge", outs(), 4'hF);
    step("R2 peer2 write sets host flag");
    p3_acc(HBOX, 1'b0, 1'b0); step("R3 peer3 write sets host flag");
    host_acc(HBOX, 1'b1, 2'b10); step("R4 host read clears lane0 flag");
    host_acc(HBOX, 1'b0, 2'b01); step("R4 host write clears lane1 flag");
    // R5 both lanes
    host_acc(PBOX, 1'b0, 2'b00); step("R5 host write sets both peer flags");
    p2_acc(PBOX, 1'b1, 1'b0); step("R6 peer2 read clears own flag");
    p3_acc(PBOX, 1'b0, 1'b0); step("R6 peer3 write clears own flag");
    // R7: ignored accesses
    p2_acc(HBOX, 1'b1, 1'b0); p3_acc(HBOX, 1'b0, 1'b1);
    host_acc(PBOX, 1'b1, 2'b00); step("R7 reads and deselected writes ignored");
    host_acc(PBOX, 1'b0, 2'b11); p2_acc(12'h7FE, 1'b0, 1'b0);
    step("R7 host lanes high and other address ignored");
    // set both host flags, then clear both lanes at once (R4)
    p2_acc(HBOX, 1'b0, 1'b0); p3_acc(HBOX, 1'b0, 1'b0); step("R2 R3 both set");
    host_acc(12'h000, 1'b0, 2'b00); step("R7 host other address ignored");
    host_acc(HBOX, 1'b1, 2'b00); step("R4 both lanes clear");
    // R8: set and clear together
    p2_acc(HBOX, 1'b0, 1'b0); host_acc(HBOX, 1'b1, 2'b10);
    step("R8 set wins over host clear");
    host_acc(PBOX, 1'b0, 2'b10); p2_acc(PBOX, 1'b1, 1'b0);
    step("R8 set wins over peer clear");
    @(negedge clk); check("R9 hold", outs(), ~exp_f);

    // sweep of concurrent accesses on all ports
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] h;
      h = (k + 1) * 32'h9E3779B1;
      h = h ^ (h >> 15);
      host_acc(pick(h[1:0]), h[2], h[4:3]);
      p2_acc(pick(h[6:5]), h[7], h[8]);
      p3_acc(pick(h[10:9]), h[11], h[12]);
      step("R9 sweep");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule